// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out the input data value seen on each pin of a general purpose I/O port. For every pin it combines four things: the direction mode, the output type (push-pull or open-drain), the pull resistor selection and the output latch bit. It also takes in the state of an optional external driver. A pin whose level cannot be determined (it floats) keeps the value it had before. Each pin's level is a registered output, and one-cycle rise and fall pulses mark a change in that level.

External agents ask to drive a pin through a single request port (valid, pin index, level), at most one request per cycle. A request that would fight the pin's own output driver is refused and flagged. The owning register file pulses one strobe when the pull or latch settings change. It pulses a second strobe when the mode or output type change. On the second strobe the block also drops any external driver that now conflicts with the pin's output stage, and flags that it did so. The configuration inputs are live values from that register file. They are only looked at on a strobe, an external request, or the first cycle after reset.

Top module: `gpio_pin_resolver`

## Requirements
- R1: A pin whose mode field is 2'b01 (output) and whose output-type bit is 0 (push-pull) resolves to its latch bit.
- R2: An output pin with output-type bit 1 (open-drain) resolves as follows. It is 0 when its latch bit is 0. With a latch bit of 1, it is 0 when a connected external driver holds it low. Otherwise it is 1 with pull field 2'b01 (up), 0 with pull field 2'b10 (down), and its previous level with any other pull field.
- R3: A pin whose mode field is not 2'b01 and that has a connected external driver resolves to that driver's level.
- R4: A non-output pin without a connected driver resolves to 1 with pull-up, 0 with pull-down, and its previous level otherwise.
- R5: `rise_o[i]` / `fall_o[i]` pulse for exactly one cycle, in the same cycle that `lvl_o[i]` goes 0→1 / 1→0. They never pulse otherwise, so a floating pin that holds its level produces no pulse.
- R6: An external request is refused on an output pin unless the pin is open-drain and the requested level is 0. A refused request leaves the connection state unchanged and raises `drv_err_o` for one cycle, one cycle after the request. An accepted request connects the driver at the requested level.
- R7: On `cfg_drv_i`, every connected driver on an output pin is disconnected if the pin is push-pull or the driver's level is high. `cfg_err_o` pulses one cycle later if at least one driver was dropped.
- R8: While reset is held, all pins are disconnected, the driven-high state is cleared and `lvl_o` is 0. The first clock edge after release resolves every pin from the current configuration.
- R9: Resolution happens on the clock edge that samples a strobe or an external request, so `lvl_o` changes one cycle after the event. With no event, `lvl_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2*NPINS | Per-pin mode field; 2'b01 = output, others behave as input |
| otype_i | input | NPINS | Per-pin output type; 1 = open-drain, 0 = push-pull |
| pull_i | input | 2*NPINS | Per-pin pull field; 2'b01 up, 2'b10 down, else none |
| latch_i | input | NPINS | Output latch bits |
| cfg_upd_i | input | 1 | Pull or latch changed: re-resolve |
| cfg_drv_i | input | 1 | Mode or output type changed: drop conflicting drivers and re-resolve |
| ext_vld_i | input | 1 | External drive request valid |
| ext_pin_i | input | IDXW | Pin index of the request |
| ext_lvl_i | input | 1 | Requested drive level |
| lvl_o | output | NPINS | Resolved pin levels |
| rise_o | output | NPINS | One-cycle rising pulse per pin |
| fall_o | output | NPINS | One-cycle falling pulse per pin |
| drv_err_o | output | 1 | External request refused |
| cfg_err_o | output | 1 | Driver dropped by a configuration change |

## Verification
All results are registered once. A strobe or request sampled at edge k shows up in `lvl_o`, the edge pulses and both error flags right after edge k. The first edge after reset release produces the initial resolution. The bench drives stimulus 5 ns after a rising edge and compares with its reference model at the falling edge. That way every comparison sees the state just after the edge that consumed the stimulus. Directed checks use literal levels worked out from the requirements. The checks on ignored configuration changes (no strobe) look at `lvl_o` in the cycles before any later event.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
   localparam logic [1:0] MODE_OUT = 2'b01;
   localparam logic [1:0] PULL_UP  = 2'b01;
   localparam logic [1:0] PULL_DN  = 2'b10;

   typedef struct packed {
      logic       is_out;
      logic       open_drn;
      logic [1:0] pull;
      logic       latch;
   } pin_cfg_t;

   function automatic logic pull_level(input logic [1:0] pull, input logic prev);
      if (pull == PULL_UP)      return 1'b1;
      else if (pull == PULL_DN) return 1'b0;
      else                      return prev;
   endfunction
endpackage

// File: rtl/gpio_drv_arb.sv
module gpio_drv_arb
   import gpio_res_pkg::*;
#(
   parameter int NPINS = 16,
   localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] out_i,
   input  logic [NPINS-1:0] od_i,
   input  logic             cfg_drv_i,
   input  logic             ext_vld_i,
   input  logic [IDXW-1:0]  ext_pin_i,
   input  logic             ext_lvl_i,
   output logic [NPINS-1:0] conn_d_o,
   output logic [NPINS-1:0] high_d_o,
   output logic             drv_err_o,
   output logic             cfg_err_o
);
   logic [NPINS-1:0] conn_q, high_q;
   logic [NPINS-1:0] conn_a, high_a, drop;
   logic             refuse, idx_ok;

   assign idx_ok = (int'(ext_pin_i) < NPINS);
   assign refuse = ext_vld_i && idx_ok && out_i[ext_pin_i]
                   && !(od_i[ext_pin_i] && !ext_lvl_i);

   always_comb begin
      conn_a = conn_q;
      high_a = high_q;
      if (ext_vld_i && idx_ok && !refuse) begin
         conn_a[ext_pin_i] = 1'b1;
         high_a[ext_pin_i] = ext_lvl_i;
      end
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_drop
      assign drop[i] = cfg_drv_i && conn_a[i] && out_i[i] && (!od_i[i] || high_a[i]);
   end

   assign conn_d_o = conn_a & ~drop;
   assign high_d_o = high_a;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conn_q    <= '0;
         high_q    <= '0;
         drv_err_o <= 1'b0;
         cfg_err_o <= 1'b0;
      end else begin
         conn_q    <= conn_d_o;
         high_q    <= high_d_o;
         drv_err_o <= refuse;
         cfg_err_o <= |drop;
      end
   end
endmodule

// File: rtl/gpio_lvl_resolve.sv
module gpio_lvl_resolve
   import gpio_res_pkg::*;
#(
   parameter int NPINS = 16
) (
   input  pin_cfg_t [NPINS-1:0] cfg_i,
   input  logic [NPINS-1:0]     conn_i,
   input  logic [NPINS-1:0]     high_i,
   input  logic [NPINS-1:0]     prev_i,
   output logic [NPINS-1:0]     lvl_o
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      always_comb begin
         if (cfg_i[i].is_out) begin
            if (!cfg_i[i].open_drn)             lvl_o[i] = cfg_i[i].latch;
            else if (!cfg_i[i].latch)           lvl_o[i] = 1'b0;
            else if (conn_i[i] && !high_i[i])   lvl_o[i] = 1'b0;
            else                                lvl_o[i] = pull_level(cfg_i[i].pull, prev_i[i]);
         end else if (conn_i[i]) begin
            lvl_o[i] = high_i[i];
         end else begin
            lvl_o[i] = pull_level(cfg_i[i].pull, prev_i[i]);
         end
      end
   end
endmodule

// File: rtl/gpio_edge_track.sv
module gpio_edge_track #(
   parameter int NPINS = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic [NPINS-1:0] lvl_d_i,
   output logic             init_o,
   output logic [NPINS-1:0] lvl_q_o,
   output logic [NPINS-1:0] rise_o,
   output logic [NPINS-1:0] fall_o
);
   logic go;
   assign go = evt_i || init_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_o  <= 1'b1;
         lvl_q_o <= '0;
         rise_o  <= '0;
         fall_o  <= '0;
      end else begin
         init_o <= 1'b0;
         if (go) begin
            lvl_q_o <= lvl_d_i;
            rise_o  <= lvl_d_i & ~lvl_q_o;
            fall_o  <= ~lvl_d_i & lvl_q_o;
         end else begin
            rise_o <= '0;
            fall_o <= '0;
         end
      end
   end
endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver
   import gpio_res_pkg::*;
#(
   parameter int NPINS = 16,
   localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*NPINS-1:0] mode_i,
   input  logic [NPINS-1:0]   otype_i,
   input  logic [2*NPINS-1:0] pull_i,
   input  logic [NPINS-1:0]   latch_i,
   input  logic               cfg_upd_i,
   input  logic               cfg_drv_i,
   input  logic               ext_vld_i,
   input  logic [IDXW-1:0]    ext_pin_i,
   input  logic               ext_lvl_i,
   output logic [NPINS-1:0]   lvl_o,
   output logic [NPINS-1:0]   rise_o,
   output logic [NPINS-1:0]   fall_o,
   output logic               drv_err_o,
   output logic               cfg_err_o
);
   if (NPINS < 2 || NPINS > 64) begin : g_bad_npins
      $error("gpio_pin_resolver: NPINS must lie in 2..64");
   end

   pin_cfg_t [NPINS-1:0] cfg;
   logic [NPINS-1:0]     is_out, conn_d, high_d, lvl_d;
   logic                 init_q;

   for (genvar i = 0; i < NPINS; i++) begin : g_cfg
      assign is_out[i]       = (mode_i[2*i +: 2] == MODE_OUT);
      assign cfg[i].is_out   = is_out[i];
      assign cfg[i].open_drn = otype_i[i];
      assign cfg[i].pull     = pull_i[2*i +: 2];
      assign cfg[i].latch    = latch_i[i];
   end

   gpio_drv_arb #(.NPINS(NPINS)) i_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .out_i     (is_out),
      .od_i      (otype_i),
      .cfg_drv_i (cfg_drv_i),
      .ext_vld_i (ext_vld_i),
      .ext_pin_i (ext_pin_i),
      .ext_lvl_i (ext_lvl_i),
      .conn_d_o  (conn_d),
      .high_d_o  (high_d),
      .drv_err_o (drv_err_o),
      .cfg_err_o (cfg_err_o)
   );

   gpio_lvl_resolve #(.NPINS(NPINS)) i_res (
      .cfg_i  (cfg),
      .conn_i (conn_d),
      .high_i (high_d),
      .prev_i (lvl_o),
      .lvl_o  (lvl_d)
   );

   gpio_edge_track #(.NPINS(NPINS)) i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (cfg_upd_i || cfg_drv_i || ext_vld_i),
      .lvl_d_i (lvl_d),
      .init_o  (init_q),
      .lvl_q_o (lvl_o),
      .rise_o  (rise_o),
      .fall_o  (fall_o)
   );

   logic unused_init;
   assign unused_init = init_q;
endmodule

// File: rtl/gpio_pin_resolver_chk.sv
module gpio_pin_resolver_chk #(
   parameter int NPINS = 16,
   localparam int IDXW = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2*NPINS-1:0] mode_i,
   input logic [NPINS-1:0]   otype_i,
   input logic [NPINS-1:0]   latch_i,
   input logic               cfg_upd_i,
   input logic               cfg_drv_i,
   input logic               ext_vld_i,
   input logic [IDXW-1:0]    ext_pin_i,
   input logic               ext_lvl_i,
   input logic [NPINS-1:0]   lvl_o,
   input logic [NPINS-1:0]   rise_o,
   input logic [NPINS-1:0]   fall_o,
   input logic               drv_err_o,
   input logic               cfg_err_o
);
   logic req_bad;
   assign req_bad = ext_vld_i && (int'(ext_pin_i) < NPINS)
                    && (mode_i[2*ext_pin_i +: 2] == 2'b01)
                    && !(otype_i[ext_pin_i] && !ext_lvl_i);

   assert_edge_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rise_o == (lvl_o & ~$past(lvl_o))) && (fall_o == (~lvl_o & $past(lvl_o))));

   assert_edge_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o & fall_o) == '0);

   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !cfg_upd_i && !cfg_drv_i && !ext_vld_i) |=> $stable(lvl_o));

   assert_refuse_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_bad |=> drv_err_o);

   assert_accept_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_bad |=> !drv_err_o);

   assert_drop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_drv_i) |=> !cfg_err_o);

   for (genvar i = 0; i < NPINS; i++) begin : g_pp
      assert_push_pull_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_upd_i && mode_i[2*i +: 2] == 2'b01 && !otype_i[i]) |=> lvl_o[i] == $past(latch_i[i]));
   end
endmodule

bind gpio_pin_resolver gpio_pin_resolver_chk #(.NPINS(NPINS)) i_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .otype_i(otype_i), .latch_i(latch_i),
   .cfg_upd_i(cfg_upd_i), .cfg_drv_i(cfg_drv_i), .ext_vld_i(ext_vld_i),
   .ext_pin_i(ext_pin_i), .ext_lvl_i(ext_lvl_i), .lvl_o(lvl_o), .rise_o(rise_o),
   .fall_o(fall_o), .drv_err_o(drv_err_o), .cfg_err_o(cfg_err_o)
);

// File: tb/test_gpio_pin_resolver.sv
`timescale 1ns/1ps
module test_gpio_pin_resolver;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2*N-1:0] mode = '0, pull = '0;
   logic [N-1:0]  otype = '0, latch = '0;
   logic          upd = 1'b0, drv = 1'b0, xv = 1'b0, xl = 1'b0;
   logic [3:0]    xp = '0;
   logic [N-1:0]  lvl, rise, fall;
   logic          derr, cerr;

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   string cur_req = "R8";

   always #10 clk = ~clk;

   gpio_pin_resolver #(.NPINS(N)) i_gpio_pin_resolver (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .otype_i(otype), .pull_i(pull),
      .latch_i(latch), .cfg_upd_i(upd), .cfg_drv_i(drv), .ext_vld_i(xv),
      .ext_pin_i(xp), .ext_lvl_i(xl), .lvl_o(lvl), .rise_o(rise), .fall_o(fall),
      .drv_err_o(derr), .cfg_err_o(cerr)
   );

   // reference model state
   bit [N-1:0] m_conn, m_high, m_lvl, m_rise, m_fall;
   bit m_derr, m_cerr, m_init;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_conn = '0; m_high = '0; m_lvl = '0; m_rise = '0; m_fall = '0;
         m_derr = 0; m_cerr = 0; m_init = 1;
      end else begin
         bit [N-1:0] nl;
         bit ev, dropped;
         ev = m_init || upd || drv || xv;
         m_derr = 0; dropped = 0;
         if (xv) begin
            bit outp;
            outp = (mode[2*xp +: 2] == 2'b01);
            if (outp && !(otype[xp] && !xl)) m_derr = 1;
            else begin m_conn[xp] = 1; m_high[xp] = xl; end
         end
         if (drv) begin
            for (int i = 0; i < N; i++) begin
               if (m_conn[i] && mode[2*i +: 2] == 2'b01 && (!otype[i] || m_high[i])) begin
                  m_conn[i] = 0; dropped = 1;
               end
            end
         end
         m_cerr = dropped;
         nl = m_lvl;
         for (int i = 0; i < N; i++) begin
            bit [1:0] p;
            p = pull[2*i +: 2];
            if (mode[2*i +: 2] == 2'b01) begin
               if (!otype[i]) nl[i] = latch[i];
               else if (!latch[i]) nl[i] = 0;
               else if (m_conn[i] && !m_high[i]) nl[i] = 0;
               else if (p == 2'b01) nl[i] = 1;
               else if (p == 2'b10) nl[i] = 0;
            end else if (m_conn[i]) nl[i] = m_high[i];
            else if (p == 2'b01) nl[i] = 1;
            else if (p == 2'b10) nl[i] = 0;
         end
         if (ev) begin
            m_rise = nl & ~m_lvl; m_fall = ~nl & m_lvl; m_lvl = nl;
         end else begin
            m_rise = '0; m_fall = '0;
         end
         m_init = 0;
      end
   end

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(negedge clk) if (!finished) begin
      chk({cur_req, " lvl"},  lvl,  m_lvl);
      chk("R5 rise", rise, m_rise);
      chk("R5 fall", fall, m_fall);
      chk("R6 drv_err", {15'd0, derr}, {15'd0, m_derr});
      chk("R7 cfg_err", {15'd0, cerr}, {15'd0, m_cerr});
   end

   task automatic cyc(); @(posedge clk); #5; endtask
   task automatic strobe_upd(); upd = 1; cyc(); upd = 0; endtask
   task automatic strobe_drv(); drv = 1; cyc(); drv = 0; endtask
   task automatic ext(input int p, input bit l); xv = 1; xp = 4'(p); xl = l; cyc(); xv = 0; endtask
   task automatic late(); @(negedge clk); #1; endtask

   function automatic logic [2*N-1:0] fill2(input logic [1:0] v);
      for (int i = 0; i < N; i++) fill2[2*i +: 2] = v;
   endfunction

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      #(20ns * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      summary();
      $finish;
   end

   initial begin
      pull = '0; pull[1:0] = 2'b01;          // pin0 pull-up during reset
      repeat (3) cyc();
      late(); chk("R8 reset", lvl, 16'h0000);
      @(posedge clk); #5; rst_n = 1;
      cyc(); late(); chk("R8 first resolve", lvl, 16'h0001);

      cur_req = "R1";
      pull = fill2(2'b11);
      mode = fill2(2'b01); otype = '0; latch = 16'hA5C3;
      strobe_upd(); late(); chk("R1 push-pull", lvl, 16'hA5C3);

      cur_req = "R9";
      latch = 16'h0000; repeat (3) cyc(); late(); chk("R9 no strobe", lvl, 16'hA5C3);

      cur_req = "R2";
      otype = '1; latch = 16'hFFF0;
      for (int i = 0; i < N; i++) pull[2*i +: 2] = (i < 4) ? 2'b01 : (i < 8) ? 2'b10 : (i < 12) ? 2'b01 : 2'b00;
      strobe_drv(); late(); chk("R2 open-drain", lvl, 16'hAF00);
      ext(9, 0); late(); chk("R2 od held low", lvl, 16'hAD00);

      cur_req = "R3";
      mode = '0; pull = fill2(2'b00);
      strobe_upd(); late(); chk("R3 input hold", lvl, 16'hAD00);
      ext(0, 1); late(); chk("R3 driven high", lvl, 16'hAD01);

      cur_req = "R4";
      pull = fill2(2'b10); strobe_upd(); late(); chk("R4 pull-down", lvl, 16'h0001);
      pull = fill2(2'b01); strobe_upd(); late(); chk("R4 pull-up", lvl, 16'hFDFF);

      cur_req = "R6";
      mode[7:6] = 2'b01; otype[3] = 0; latch[3] = 0;
      strobe_drv(); late(); chk("R6 pp out", lvl, 16'hFDF7);
      ext(3, 1); late();
      chk("R6 refused flag", {15'd0, derr}, 16'h0001);
      chk("R6 level kept", lvl, 16'hFDF7);

      cur_req = "R7";
      mode[1:0] = 2'b01; otype[0] = 1; latch[0] = 0;
      strobe_drv(); late();
      chk("R7 drop flag", {15'd0, cerr}, 16'h0001);
      mode[1:0] = 2'b00; pull[1:0] = 2'b10;
      strobe_upd(); late(); chk("R7 pin0 disconnected", lvl, 16'hFDF6);

      cur_req = "R5";
      for (int k = 0; k < 600; k++) begin
         mode = {$urandom, $urandom}; otype = 16'($urandom);
         pull = {$urandom, $urandom}; latch = 16'($urandom);
         upd = ($urandom % 4) == 0; drv = ($urandom % 5) == 0;
         xv = ($urandom % 3) == 0; xp = 4'($urandom); xl = 1'($urandom);
         cyc();
      end
      upd = 0; drv = 0; xv = 0;
      cyc(); late();
      finished = 1;
      summary();
      $finish;
   end
endmodule